// File: doc/BRIEF.md
# Remapping-Unit Command Port

This block is the command front end of a DMA remapping unit, reached through 64-bit register writes and reads. Software may first place a second operand in its own register. It then writes a command word, which holds an 8-bit opcode in its low byte and a first operand from bit 16 upward. The port accepts the word and sets a busy flag in the response register. It executes the command over a fixed number of cycles, then clears the flag and posts a 7-bit status next to it.

The opcodes the unit implements are listed in a constant bitmap of 256 bits, read as four 64-bit capability words. An opcode whose bit is clear is refused with a fixed error status. The implemented executor controls performance counters. Two opcodes switch counting on and off, and two more stop and restart it. The result is a two-bit control vector for the counter block. A separate output shows whether all four counter opcodes are advertised.

Top module: `remap_cmd_if`

## Requirements
- R1: After reset, the command, operand and response registers read zero and the counter control vector is 00.
- R2: Capability word k (k = 0..3) reads at byte offset 0x430 + 8*k. Bit (n mod 64) of word (n / 64) is 1 exactly when opcode n is implemented. With the default map, word 0 reads 0x4, words 1 and 2 read 0, and word 3 reads 0x0033000000000000.
- R3: A write to offset 0x400 while the port is idle latches the word, which reads back at 0x400. Response bit 0 (busy) is 1 from the clock edge of that write onward, and bits 7:1 read 0 while the command runs.
- R4: Busy stays set for EXEC_CYCLES (default 4) clock edges and clears on the last of them. At that edge the status appears in response bits 7:1, and 0 there means success.
- R5: Opcode 0xF0 sets control bit 0 (counting on) and 0xF1 clears it. Opcode 0xF4 sets control bit 1 (frozen) and 0xF5 clears it. The change takes effect on the edge where busy clears.
- R6: An opcode whose capability bit is 0 completes without touching the control vector and posts status 1, so the response reads 0x2.
- R7: A write to 0x400 while busy is set is dropped. The latched command, its outcome and the response are the same as they would be without the write.
- R8: A write to offset 0x408 latches the second operand, which reads back there. It changes neither the response nor the control vector.
- R9: Writes to the response register (0x410) and to the capability words leave their read values unchanged.
- R10: Output cntFeature is 1 exactly when opcodes 0xF0, 0xF1, 0xF4 and 0xF5 are all implemented, that is, bits 48, 49, 52 and 53 of capability word 3. It is 1 with the default map.
- R11: An implemented opcode with no counter action (0x02 in the default map) completes with status 0 and leaves the control vector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, sampled at the clock edge |
| wrAddr | input | 12 | Byte offset of the write |
| wrData | input | 64 | Write data |
| rdAddr | input | 12 | Byte offset of the read |
| rdData | output | 64 | Read data, combinational from rdAddr; unmapped offsets read 0 |
| cntCtl | output | 2 | Counter control: bit 0 counting on, bit 1 frozen |
| cntFeature | output | 1 | All four counter opcodes are advertised |

## Verification
A command written at edge E reads busy from just after E. With the default latency, the response stays at 0x1 up to the fourth edge after E. Status and control vector change together at edge E+4. The bench drives every write on a falling edge, so the write lands on the next rising edge. It counts falling edges from there and checks busy right after E, still busy just before E+4, and the final status and control half a cycle after E+4. Each write that should be ignored is placed inside that window or while the port is idle. The checks then read the affected registers and outputs before the next stimulus.

// File: rtl/remap_cmd_pkg.sv
package remap_cmd_pkg;
  localparam int DATA_W   = 64;
  localparam int ADDR_W   = 12;
  localparam int OP_W     = 8;
  localparam int STAT_W   = 7;
  localparam int NUM_OPS  = 1 << OP_W;

  localparam logic [ADDR_W-1:0] CMD_OFS  = 12'h400;
  localparam logic [ADDR_W-1:0] OPB_OFS  = 12'h408;
  localparam logic [ADDR_W-1:0] RESP_OFS = 12'h410;
  localparam logic [ADDR_W-1:0] CAP_OFS  = 12'h430;
  localparam int                WORD_STEP = 8;

  localparam logic [OP_W-1:0] OP_CNT_ON    = 8'hF0;
  localparam logic [OP_W-1:0] OP_CNT_OFF   = 8'hF1;
  localparam logic [OP_W-1:0] OP_CNT_HOLD  = 8'hF4;
  localparam logic [OP_W-1:0] OP_CNT_RESUME = 8'hF5;

  localparam logic [STAT_W-1:0] STAT_OK      = 7'd0;
  localparam logic [STAT_W-1:0] STAT_BAD_OP  = 7'd1;

  localparam logic [NUM_OPS-1:0] DEFAULT_CAPS =
      (NUM_OPS'(1) << OP_CNT_ON) | (NUM_OPS'(1) << OP_CNT_OFF) |
      (NUM_OPS'(1) << OP_CNT_HOLD) | (NUM_OPS'(1) << OP_CNT_RESUME) |
      (NUM_OPS'(1) << 2);

  typedef struct packed {
    logic loadCmd;
    logic loadOpb;
    logic finish;
  } strobe_t;
endpackage

// File: rtl/remap_cmd_ctrl.sv
module remap_cmd_ctrl
  import remap_cmd_pkg::*;
#(
  parameter int EXEC_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output strobe_t           strb,
  output logic              busy
);
  localparam int CNT_W = $clog2(EXEC_CYCLES + 1);

  logic [CNT_W-1:0] remain;

  always_comb begin
    strb.loadCmd = wrEn && (wrAddr == CMD_OFS) && !busy;
    strb.loadOpb = wrEn && (wrAddr == OPB_OFS);
    strb.finish  = busy && (remain == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (strb.loadCmd) begin
      busy   <= 1'b1;
      remain <= CNT_W'(EXEC_CYCLES - 1);
    end else if (strb.finish) begin
      busy   <= 1'b0;
    end else if (busy) begin
      remain <= remain - 1'b1;
    end
  end

  // R3: an accepted command raises busy on the following edge
  assert_busy_after_launch_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCmd |=> busy);
  // R4: completion drops busy
  assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !busy);
  // R4: the remaining-cycle count stays inside the execution window
  assert_window_bounded_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (int'(remain) < EXEC_CYCLES));
endmodule

// File: rtl/remap_cmd_dp.sv
module remap_cmd_dp
  import remap_cmd_pkg::*;
#(
  parameter logic [NUM_OPS-1:0] CAP_MAP = DEFAULT_CAPS
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              busy,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        cntCtl,
  output logic              cntFeature
);
  localparam int CAP_WORDS = NUM_OPS / DATA_W;

  logic [DATA_W-1:0] cmdReg;
  logic [DATA_W-1:0] opbReg;
  logic [STAT_W-1:0] status;
  logic [DATA_W-1:0] capWords [CAP_WORDS];
  logic [OP_W-1:0]   curOp;
  logic              capHit;

  for (genvar k = 0; k < CAP_WORDS; k++) begin : g_cap
    assign capWords[k] = CAP_MAP[k*DATA_W +: DATA_W];
  end

  assign curOp      = cmdReg[OP_W-1:0];
  assign capHit     = CAP_MAP[curOp];
  assign cntFeature = CAP_MAP[OP_CNT_ON] & CAP_MAP[OP_CNT_OFF] &
                      CAP_MAP[OP_CNT_HOLD] & CAP_MAP[OP_CNT_RESUME];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
      opbReg <= '0;
      status <= '0;
      cntCtl <= '0;
    end else begin
      if (strb.loadOpb) opbReg <= wrData;
      if (strb.loadCmd) begin
        cmdReg <= wrData;
        status <= STAT_OK;
      end else if (strb.finish) begin
        if (capHit) begin
          status <= STAT_OK;
          case (curOp)
            OP_CNT_ON:     cntCtl[0] <= 1'b1;
            OP_CNT_OFF:    cntCtl[0] <= 1'b0;
            OP_CNT_HOLD:   cntCtl[1] <= 1'b1;
            OP_CNT_RESUME: cntCtl[1] <= 1'b0;
            default:       ;
          endcase
        end else begin
          status <= STAT_BAD_OP;
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == CMD_OFS)  rdData = cmdReg;
    if (rdAddr == OPB_OFS)  rdData = opbReg;
    if (rdAddr == RESP_OFS) rdData = {{(DATA_W-STAT_W-1){1'b0}}, status, busy};
    for (int k = 0; k < CAP_WORDS; k++) begin
      if (rdAddr == CAP_OFS + ADDR_W'(k*WORD_STEP)) rdData = capWords[k];
    end
  end

  // R7: a command write during execution leaves the latched command alone
  assert_ignored_cmd_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == CMD_OFS && busy) |=> $stable(cmdReg));
  // R6: refused opcode posts the error code and leaves the control vector
  assert_bad_op_status_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && !capHit) |=> (status == STAT_BAD_OP && $stable(cntCtl)));
  // R8: latching the second operand has no other effect
  assert_opb_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadOpb && !strb.finish && !strb.loadCmd) |=> ($stable(cntCtl) && $stable(status)));
  // R3: status reads zero while a command runs
  assert_status_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCmd |=> (status == STAT_OK));
endmodule

// File: rtl/remap_cmd_if.sv
module remap_cmd_if
  import remap_cmd_pkg::*;
#(
  parameter int                 EXEC_CYCLES = 4,
  parameter logic [NUM_OPS-1:0] CAP_MAP     = DEFAULT_CAPS
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [11:0] wrAddr,
  input  logic [63:0] wrData,
  input  logic [11:0] rdAddr,
  output logic [63:0] rdData,
  output logic [1:0]  cntCtl,
  output logic        cntFeature
);
  strobe_t strb;
  logic    busy;

  remap_cmd_ctrl #(.EXEC_CYCLES(EXEC_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .strb(strb), .busy(busy)
  );

  remap_cmd_dp #(.CAP_MAP(CAP_MAP)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .cntCtl(cntCtl), .cntFeature(cntFeature)
  );
endmodule

// File: tb/tb_remap_cmd_if.sv
module tb_remap_cmd_if;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] wrAddr = '0;
  logic [63:0] wrData = '0;
  logic [11:0] rdAddr = '0;
  logic [63:0] rdData;
  logic [1:0]  cntCtl;
  logic        cntFeature;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  remap_cmd_if dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .cntCtl(cntCtl), .cntFeature(cntFeature)
  );

  // {opcode, control vector after, status after}
  localparam logic [16:0] VEC [9] = '{
    {8'hF0, 2'b01, 7'd0}, {8'hF4, 2'b11, 7'd0}, {8'hF4, 2'b11, 7'd0},
    {8'hF5, 2'b01, 7'd0}, {8'h02, 2'b01, 7'd0}, {8'h33, 2'b01, 7'd1},
    {8'hF1, 2'b00, 7'd0}, {8'hF5, 2'b00, 7'd0}, {8'hFF, 2'b00, 7'd1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  // drive at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [63:0] cmdWord;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(12'h400, v); chk("R1 cmd", v, 64'h0);
    rd(12'h408, v); chk("R1 opb", v, 64'h0);
    rd(12'h410, v); chk("R1 resp", v, 64'h0);
    chk("R1 ctl", {62'h0, cntCtl}, 64'h0);

    // R2 capability words
    rd(12'h430, v); chk("R2 cap0", v, 64'h4);
    rd(12'h438, v); chk("R2 cap1", v, 64'h0);
    rd(12'h440, v); chk("R2 cap2", v, 64'h0);
    rd(12'h448, v); chk("R2 cap3", v, 64'h0033000000000000);
    // R10 feature flag
    chk("R10 feature", {63'h0, cntFeature}, 64'h1);

    // table walk: R3 busy, R4 latency/status, R5 control, R6 refusal, R11 plain op
    for (int i = 0; i < 9; i++) begin
      cmdWord = (64'(i + 1) << 16) | 64'(VEC[i][16:9]);
      wr(12'h400, cmdWord);
      rd(12'h410, v); chk("R3 busy after write", v, 64'h1);
      rd(12'h400, v); chk("R3 cmd readback", v, cmdWord);
      repeat (3) @(negedge clk);
      rd(12'h410, v); chk("R4 still busy before last edge", v, 64'h1);
      @(negedge clk);
      rd(12'h410, v);
      if (VEC[i][6:0] != 0) chk("R6 refused status", v, 64'h2);
      else                  chk("R4 done status", v, 64'h0);
      if (VEC[i][16:9] == 8'h02) chk("R11 ctl", {62'h0, cntCtl}, {62'h0, VEC[i][8:7]});
      else                       chk("R5 ctl", {62'h0, cntCtl}, {62'h0, VEC[i][8:7]});
    end

    // R7 write during busy is dropped
    cmdWord = (64'hAB << 16) | 64'hF0;
    wr(12'h400, cmdWord);
    wr(12'h400, 64'hF1);
    rd(12'h410, v); chk("R7 resp during run", v, 64'h1);
    rd(12'h400, v); chk("R7 cmd kept", v, cmdWord);
    repeat (2) @(negedge clk);
    rd(12'h410, v); chk("R7 resp done", v, 64'h0);
    chk("R7 ctl from first cmd", {62'h0, cntCtl}, 64'h1);
    repeat (6) @(negedge clk);
    chk("R7 no second run", {62'h0, cntCtl}, 64'h1);
    rd(12'h410, v); chk("R7 resp idle", v, 64'h0);

    // R8 second operand
    wr(12'h408, 64'h0123_4567_89AB_CDEF);
    rd(12'h408, v); chk("R8 opb readback", v, 64'h0123_4567_89AB_CDEF);
    rd(12'h410, v); chk("R8 resp unchanged", v, 64'h0);
    repeat (5) @(negedge clk);
    chk("R8 ctl unchanged", {62'h0, cntCtl}, 64'h1);
    rd(12'h410, v); chk("R8 no command started", v, 64'h0);

    // R9 read-only registers
    wr(12'h410, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(12'h410, v); chk("R9 resp write", v, 64'h0);
    wr(12'h448, 64'h0);
    rd(12'h448, v); chk("R9 cap3 write", v, 64'h0033000000000000);
    wr(12'h430, 64'hFFFF);
    rd(12'h430, v); chk("R9 cap0 write", v, 64'h4);
    chk("R9 ctl", {62'h0, cntCtl}, 64'h1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule